// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides, for each received CAN frame identifier, whether the frame is kept and where it goes. It holds a parameterised number of filter banks, each made of two 32-bit registers and four per-bank control bits (mode, scale, destination queue, enable). A bank in mask mode treats its registers as a pattern and a care-mask. In list mode the registers are exact identifiers to compare against. The scale bit selects whether a bank forms one 32-bit filter or splits into 16-bit halves, which gives two mask filters or four list entries.

A configuration port writes a filter-setup flag, the four per-bank control words and the bank registers. The control words for mode, scale and queue can only change while the setup flag is set. The match port takes an 11-bit standard identifier, an 18-bit extension, the IDE and RTR flags and one valid strobe. One cycle later it returns accept, the receive queue select and the number of the winning bank. Frame reception and bit timing are handled elsewhere.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the setup flag is 1, every control word and bank register is 0 (no bank enabled) and res_valid_o is 0. With setup then cleared, no frame is accepted.
- R2: Writes to the mode (cfg_sel_i=1), scale (2) and queue (3) words are ignored while the setup flag (cfg_sel_i=0, bit 0 of data) is 0. The enable word (4) may be written at any time. Bit n of each word belongs to bank n.
- R3: res_valid_o is high in exactly the cycle after each cycle with req_valid_i high. While the setup flag is 1, res_accept_o is 0.
- R4: The 32-bit compare word is {stid[10:0], exid[17:0], ide, rtr, 1'b0}. The 16-bit compare word is {stid[10:0], rtr, ide, exid[17:15]}.
- R5: Mode bit 0 with scale bit 1 is 32-bit mask mode. Register 1 is the pattern and register 2 the mask. A hit occurs when ((word ^ reg1) & reg2) == 0, so an all-zero mask accepts every frame.
- R6: Mode bit 1 with scale bit 1 is 32-bit list mode. A hit occurs when word[31:1] equals bits [31:1] of either register.
- R7: Mode bit 0 with scale bit 0 gives two 16-bit mask filters. In each register the low half is the pattern and the high half the mask.
- R8: Mode bit 1 with scale bit 0 gives four 16-bit list entries, the low and high halves of both registers. A hit is an exact match with any of them.
- R9: A bank whose enable bit is 0 never produces a hit.
- R10: When several enabled banks hit, the lowest-numbered bank wins and its number is returned on res_index_o. With no accept, res_index_o and res_fifo_o are 0.
- R11: res_fifo_o equals the queue bit of the winning bank (0 selects queue 0, 1 selects queue 1).
- R12: A bank register write (cfg_sel_i=5 for register 1, 6 for register 2) is ignored when the setup flag is 0 and the bank is enabled. It takes effect otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Target: 0 setup flag, 1 mode, 2 scale, 3 queue, 4 enable, 5 register 1, 6 register 2 |
| cfg_bank_i | input | BANK_W | Bank number for register writes |
| cfg_wdata_i | input | 32 | Write data |
| req_valid_i | input | 1 | Match request strobe |
| req_stid_i | input | 11 | Standard identifier |
| req_exid_i | input | 18 | Identifier extension |
| req_ide_i | input | 1 | Extended-format flag |
| req_rtr_i | input | 1 | Remote-request flag |
| res_valid_o | output | 1 | Result strobe, one cycle after request |
| res_accept_o | output | 1 | Frame accepted |
| res_fifo_o | output | 1 | Destination receive queue |
| res_index_o | output | BANK_W | Winning bank number |

## Verification
A corrupted control bit or bank register does not raise a flag. It shows only as a wrong accept, queue or index on the next request that reaches the affected bank, one cycle after that request. The bench therefore places each bank in a different mode and probes it with identifiers on both sides of its pattern. It also overlaps banks so that the priority and enable paths show up in the index. Ignored writes are checked by probing the affected bank right after the write.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  typedef enum logic [2:0] {
    CFG_INIT  = 3'd0,
    CFG_MODE  = 3'd1,
    CFG_SCALE = 3'd2,
    CFG_FIFO  = 3'd3,
    CFG_ACT   = 3'd4,
    CFG_REG1  = 3'd5,
    CFG_REG2  = 3'd6
  } cfg_sel_e;

  function automatic logic [31:0] pack_w32(logic [10:0] stid, logic [17:0] exid,
                                           logic ide, logic rtr);
    return {stid, exid, ide, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] pack_w16(logic [10:0] stid, logic [17:0] exid,
                                           logic ide, logic rtr);
    return {stid, rtr, ide, exid[17:15]};
  endfunction

endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS = 28,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [2:0]           sel_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [31:0]          wdata_i,
  output logic                 init_o,
  output logic [NUM_BANKS-1:0] mode_o,
  output logic [NUM_BANKS-1:0] scale_o,
  output logic [NUM_BANKS-1:0] fifo_o,
  output logic [NUM_BANKS-1:0] act_o,
  output logic [31:0]          reg1_o [NUM_BANKS],
  output logic [31:0]          reg2_o [NUM_BANKS]
);

  logic                 init_q;
  logic [NUM_BANKS-1:0] mode_q, scale_q, fifo_q, act_q;
  logic [31:0]          reg1_q [NUM_BANKS];
  logic [31:0]          reg2_q [NUM_BANKS];
  cfg_sel_e             sel;
  logic                 ctl_wr_ok, bank_ok;

  assign sel       = cfg_sel_e'(sel_i);
  assign ctl_wr_ok = we_i && init_q;
  assign bank_ok   = (32'(bank_i) < NUM_BANKS) && (init_q || !act_q[bank_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      mode_q  <= '0;
      scale_q <= '0;
      fifo_q  <= '0;
      act_q   <= '0;
    end else if (we_i) begin
      case (sel)
        CFG_INIT:  init_q <= wdata_i[0];
        CFG_MODE:  if (ctl_wr_ok) mode_q  <= wdata_i[NUM_BANKS-1:0];
        CFG_SCALE: if (ctl_wr_ok) scale_q <= wdata_i[NUM_BANKS-1:0];
        CFG_FIFO:  if (ctl_wr_ok) fifo_q  <= wdata_i[NUM_BANKS-1:0];
        CFG_ACT:   act_q <= wdata_i[NUM_BANKS-1:0];
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg1_q[b] <= '0;
        reg2_q[b] <= '0;
      end else if (we_i && bank_ok && 32'(bank_i) == b) begin
        if (sel == CFG_REG1) reg1_q[b] <= wdata_i;
        if (sel == CFG_REG2) reg2_q[b] <= wdata_i;
      end
    end
    assign reg1_o[b] = reg1_q[b];
    assign reg2_o[b] = reg2_q[b];
  end

  assign init_o  = init_q;
  assign mode_o  = mode_q;
  assign scale_o = scale_q;
  assign fifo_o  = fifo_q;
  assign act_o   = act_q;

  // R2
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && we_i && sel_i == 3'd1) |=> $stable(mode_q));

  // R2
  fifo_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && we_i && sel_i == 3'd3) |=> $stable(fifo_q));

endmodule

// File: rtl/can_filt_bank_match.sv
module can_filt_bank_match (
  input  logic        mode_i,   // 0 mask, 1 list
  input  logic        scale_i,  // 0 dual 16-bit, 1 single 32-bit
  input  logic [31:0] reg1_i,
  input  logic [31:0] reg2_i,
  input  logic [31:0] w32_i,
  input  logic [15:0] w16_i,
  output logic        hit_o
);

  logic mask32, list32, mask16, list16;

  always_comb begin
    mask32 = ((w32_i ^ reg1_i) & reg2_i) == 32'd0;
    list32 = (w32_i[31:1] == reg1_i[31:1]) || (w32_i[31:1] == reg2_i[31:1]);
    mask16 = (((w16_i ^ reg1_i[15:0]) & reg1_i[31:16]) == 16'd0) ||
             (((w16_i ^ reg2_i[15:0]) & reg2_i[31:16]) == 16'd0);
    list16 = (w16_i == reg1_i[15:0]) || (w16_i == reg1_i[31:16]) ||
             (w16_i == reg2_i[15:0]) || (w16_i == reg2_i[31:16]);
    case ({scale_i, mode_i})
      2'b10:   hit_o = mask32;
      2'b11:   hit_o = list32;
      2'b00:   hit_o = mask16;
      default: hit_o = list16;
    endcase
  end

endmodule

// File: rtl/can_filt_arb.sv
module can_filt_arb #(
  parameter int NUM_BANKS = 28,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0] hit_i,
  output logic                 any_o,
  output logic [BANK_W-1:0]    idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hit_i[b]) begin
        any_o = 1'b1;
        idx_o = BANK_W'(b);
      end
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS = 28,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [10:0]       req_stid_i,
  input  logic [17:0]       req_exid_i,
  input  logic              req_ide_i,
  input  logic              req_rtr_i,
  output logic              res_valid_o,
  output logic              res_accept_o,
  output logic              res_fifo_o,
  output logic [BANK_W-1:0] res_index_o
);

  logic                 init;
  logic [NUM_BANKS-1:0] mode_vec, scale_vec, fifo_vec, act_vec;
  logic [31:0]          reg1 [NUM_BANKS];
  logic [31:0]          reg2 [NUM_BANKS];
  logic [NUM_BANKS-1:0] raw_hit, hit_vec;
  logic [31:0]          w32;
  logic [15:0]          w16;
  logic                 any_hit, take;
  logic [BANK_W-1:0]    win_idx;

  logic              valid_q, accept_q, fifo_q;
  logic [BANK_W-1:0] idx_q;

  can_filt_cfg #(.NUM_BANKS(NUM_BANKS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .bank_i  (cfg_bank_i),
    .wdata_i (cfg_wdata_i),
    .init_o  (init),
    .mode_o  (mode_vec),
    .scale_o (scale_vec),
    .fifo_o  (fifo_vec),
    .act_o   (act_vec),
    .reg1_o  (reg1),
    .reg2_o  (reg2)
  );

  assign w32 = pack_w32(req_stid_i, req_exid_i, req_ide_i, req_rtr_i);
  assign w16 = pack_w16(req_stid_i, req_exid_i, req_ide_i, req_rtr_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    can_filt_bank_match u_match (
      .mode_i  (mode_vec[b]),
      .scale_i (scale_vec[b]),
      .reg1_i  (reg1[b]),
      .reg2_i  (reg2[b]),
      .w32_i   (w32),
      .w16_i   (w16),
      .hit_o   (raw_hit[b])
    );
  end

  assign hit_vec = raw_hit & act_vec;

  can_filt_arb #(.NUM_BANKS(NUM_BANKS)) u_arb (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  assign take = any_hit && !init;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      fifo_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        accept_q <= take;
        fifo_q   <= take ? fifo_vec[win_idx] : 1'b0;
        idx_q    <= take ? win_idx : '0;
      end
    end
  end

  assign res_valid_o  = valid_q;
  assign res_accept_o = accept_q;
  assign res_fifo_o   = fifo_q;
  assign res_index_o  = idx_q;

  // R3
  res_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);

  // R3
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);

  // R3
  init_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && init) |=> !res_accept_o);

  // R10
  lowest_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> (hit_vec[win_idx] &&
                 ((hit_vec & ((NUM_BANKS'(1) << win_idx) - NUM_BANKS'(1))) == '0)));

  // R9
  enabled_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && any_hit) |-> act_vec[win_idx]);

  // R10
  no_accept_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_accept_o) |-> (res_index_o == '0 && !res_fifo_o));

endmodule

// File: tb/can_accept_filter_tb_top.sv
module can_accept_filter_tb_top;

  localparam int NB = 28;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [BW-1:0] cfg_bank = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [10:0]   req_stid = '0;
  logic [17:0]   req_exid = '0;
  logic          req_ide = 1'b0;
  logic          req_rtr = 1'b0;
  logic          res_valid, res_accept, res_fifo;
  logic [BW-1:0] res_index;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic          acc;
    logic          fifo;
    logic [BW-1:0] idx;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  can_accept_filter #(.NUM_BANKS(NB)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_sel_i    (cfg_sel),
    .cfg_bank_i   (cfg_bank),
    .cfg_wdata_i  (cfg_wdata),
    .req_valid_i  (req_valid),
    .req_stid_i   (req_stid),
    .req_exid_i   (req_exid),
    .req_ide_i    (req_ide),
    .req_rtr_i    (req_rtr),
    .res_valid_o  (res_valid),
    .res_accept_o (res_accept),
    .res_fifo_o   (res_fifo),
    .res_index_o  (res_index)
  );

  function automatic logic [31:0] w32(logic [10:0] s, logic [17:0] e, logic i, logic r);
    return {s, e, i, r, 1'b0};
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input int bank, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_bank = BW'(bank); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [10:0] s, input logic [17:0] e, input logic i,
                       input logic r, input logic acc, input logic fifo,
                       input int idx, input string tag);
    exp_t x;
    x.acc = acc; x.fifo = fifo; x.idx = BW'(idx); x.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_stid = s; req_exid = e; req_ide = i; req_rtr = r;
    exp_q.push_back(x);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && res_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R3: unexpected result strobe, got valid=1 expected 0");
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        n_tests++;
        if (res_accept !== x.acc || res_fifo !== x.fifo || res_index !== x.idx) begin
          n_fail++;
          $display("FAIL %s: got acc=%0d fifo=%0d idx=%0d expected acc=%0d fifo=%0d idx=%0d",
                   x.tag, res_accept, res_fifo, res_index, x.acc, x.fifo, x.idx);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: res_valid after reset got %0d expected 0", res_valid);
    end
    // R3: setup flag set from reset, nothing accepted
    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R3 init blocks");
    // R1: all banks disabled after reset
    cfg_write(3'd0, 0, 32'd0);
    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R1 no bank enabled");
    cfg_write(3'd0, 0, 32'd1);

    // bank setup
    cfg_write(3'd5, 0, 32'h123 << 21);
    cfg_write(3'd6, 0, 32'h7FF << 21);
    cfg_write(3'd5, 3, w32(11'h155, 18'h2AAAA, 1'b1, 1'b0));
    cfg_write(3'd6, 3, w32(11'h0AA, 18'h0, 1'b0, 1'b1));
    cfg_write(3'd5, 5, {16'hFFE0, 16'h6000});
    cfg_write(3'd6, 5, {16'hFFFF, 16'h6030});
    cfg_write(3'd5, 7, 32'h0400_0200);
    cfg_write(3'd6, 7, 32'h080D_0600);
    cfg_write(3'd2, 0, 32'h0000_0409);
    cfg_write(3'd1, 0, 32'h0000_0088);
    cfg_write(3'd3, 0, 32'h0000_0028);
    cfg_write(3'd4, 0, 32'h0000_00A9);
    cfg_write(3'd0, 0, 32'd0);

    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R5 R4 mask32 hit");
    probe(11'h124, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R5 mask32 miss");
    probe(11'h123, 18'h3, 1'b1, 1'b1, 1'b1, 1'b0, 0, "R5 dont-care bits");
    probe(11'h155, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 3, "R6 R11 list32 reg1");
    probe(11'h0AA, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 3, "R6 list32 reg2");
    probe(11'h155, 18'h2AAAA, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R6 R4 rtr differs");
    probe(11'h300, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 5, "R7 mask16 filter A");
    probe(11'h301, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 5, "R7 mask16 filter B");
    probe(11'h301, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R7 mask16 miss");
    probe(11'h030, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 7, "R8 list16 entry2");
    probe(11'h040, 18'h28000, 1'b1, 1'b0, 1'b1, 1'b0, 7, "R8 R4 list16 entry3");
    probe(11'h040, 18'h0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R8 list16 miss");

    // enable bank 10 (all-zero mask, 32-bit) while setup flag clear
    cfg_write(3'd4, 0, 32'h0000_04A9);
    probe(11'h124, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10, "R9 R5 zero mask accepts");
    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R10 lowest bank wins");
    probe(11'h155, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 3, "R10 R11 bank3 over bank10");

    // gated control writes
    cfg_write(3'd3, 0, 32'hFFFF_FFFF);
    probe(11'h124, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10, "R2 queue write ignored");
    cfg_write(3'd1, 0, 32'h0000_0089);
    probe(11'h123, 18'h0, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R2 mode write ignored");
    cfg_write(3'd2, 0, 32'h0);
    probe(11'h155, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 3, "R2 scale write ignored");

    // bank register write protection
    cfg_write(3'd5, 0, 32'h200 << 21);
    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R12 write to active bank ignored");
    cfg_write(3'd4, 0, 32'h0000_04A8);
    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10, "R9 disabled bank0");
    cfg_write(3'd5, 0, 32'h200 << 21);
    cfg_write(3'd4, 0, 32'h0000_04A9);
    probe(11'h200, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R12 write to disabled bank applied");
    probe(11'h123, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10, "R12 old pattern gone");

    // setup flag set again blocks acceptance
    cfg_write(3'd0, 0, 32'd1);
    probe(11'h200, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R3 setup blocks again");

    repeat (3) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: pending results got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule